// File: doc/BRIEF.md
# Buffer-to-Memory Block Copy Engine

This block moves one contiguous block of data between the 16-bit data buffer port of a flash controller and 32-bit system memory. Software sets up the source and destination addresses, a per-side configuration word, a byte count and a direction through a 32-bit register bus. It then writes a start command. The engine steps through the block one access at a time on two simple request/acknowledge ports. It packs or splits halfwords as the direction requires, and it marks the last beat of each memory-side burst.

On completion or on a fault the engine raises sticky flags in its status register. These flags clear only when software writes dedicated command bits. The same events are also latched into a small interrupt block that has its own mask, pending view and write-one-to-clear register, and this block drives a single interrupt line.

Top module: `bufDmaEngine`

## Requirements
- R1: After reset every register reads zero, both request outputs are low, the irq output is low and both interrupt sources are unmasked.
- R2: Register offsets are fixed: 0x400 source address, 0x404 source config, 0x408 destination address, 0x40C destination config, 0x414 byte count, 0x418 command, 0x41C status, 0x420 direction, 0x1004 interrupt clear, 0x1024 interrupt mask, 0x1044 interrupt pending, 0x1064 interrupt status. Address and count registers read back as written. A config register keeps only bits [18:16] (burst code), bit 8 (1 = constant address) and bits [1:0] (width code). Direction keeps bit 0. Command and clear read as zero.
- R3: With direction 0, the engine reads two halfwords from the buffer port and then writes one word to the memory port. The halfword at the lower address goes to bits [15:0]. The source address advances by 2 per halfword and the destination by 4 per word.
- R4: With direction 1, the engine reads one word from the memory port and then writes bits [15:0] to the buffer at the lower address, followed by bits [31:16]. The source advances by 4 and the destination by 2 per halfword.
- R5: When bit 8 of a side's config is set, every access on that side uses the programmed address unchanged.
- R6: memLast is high on the final beat of every group of N memory-side beats, counted from the start of the transfer, and on the final beat of the transfer. N comes from the burst code of the memory side's config (destination for direction 0, source for direction 1): code 2 gives 4, code 3 gives 8, code 4 gives 16, and any other code gives 1.
- R7: Status bit 17 (busy) is high while a transfer runs. Bit 18 (done) sets when the last word completes and stays set until a command write with bit 18. Bit 16 (error) stays set until a command write with bit 16.
- R8: A start (command bit 0) with a byte count of zero or a count that is not a multiple of 4 sets the error flag and issues no access. A start while busy sets the error flag and lets the running transfer finish unchanged.
- R9: An error response on either port ends the transfer at once: busy clears, the error flag sets, and no further request is issued.
- R10: Interrupt status bit 24 latches when done sets and bit 16 latches when error sets. A set mask bit hides that source. Pending reads status AND NOT mask. irq is high while any pending bit is set. Writing ones to the clear register clears those status bits.
- R11: When a flag or interrupt-status bit is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 16 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| bufReq | output | 1 | Buffer port request, held until ack or error |
| bufWe | output | 1 | Buffer port write (1) or read (0) |
| bufAddr | output | 32 | Buffer port byte address |
| bufWrData | output | 16 | Buffer port write halfword |
| bufRdData | input | 16 | Buffer port read halfword, valid with ack |
| bufAck | input | 1 | Buffer port access complete |
| bufErr | input | 1 | Buffer port error response |
| memReq | output | 1 | Memory port request, held until ack or error |
| memWe | output | 1 | Memory port write (1) or read (0) |
| memAddr | output | 32 | Memory port byte address |
| memWrData | output | 32 | Memory port write word |
| memRdData | input | 32 | Memory port read word, valid with ack |
| memAck | input | 1 | Memory port access complete |
| memErr | input | 1 | Memory port error response |
| memLast | output | 1 | Last beat of a memory-side burst |
| irq | output | 1 | Interrupt request |

## Verification
A transfer's final acknowledge can land on the same clock edge as a register write that clears the done flag, or one that clears the interrupt status bit. The bench provokes this by having its memory responder place the clear write on the bus in the same cycle as it acknowledges the last expected memory write. After the transfer ends, it reads status and interrupt status back and expects the bit still set, because setting takes priority over clearing. A later clear on its own must then drop the bit, which shows the earlier result came from the coincidence and not from a clear that had no effect.

// File: rtl/bufDmaPkg.sv
package bufDmaPkg;
  localparam int REG_AW   = 16;
  localparam int REG_DW   = 32;
  localparam int NARROW_W = 16;
  localparam int WIDE_W   = 32;
  localparam int BEAT_W   = 4;

  localparam logic [REG_AW-1:0] OFF_SRC_ADDR = 16'h0400;
  localparam logic [REG_AW-1:0] OFF_SRC_CFG  = 16'h0404;
  localparam logic [REG_AW-1:0] OFF_DST_ADDR = 16'h0408;
  localparam logic [REG_AW-1:0] OFF_DST_CFG  = 16'h040C;
  localparam logic [REG_AW-1:0] OFF_SIZE     = 16'h0414;
  localparam logic [REG_AW-1:0] OFF_CMD      = 16'h0418;
  localparam logic [REG_AW-1:0] OFF_STAT     = 16'h041C;
  localparam logic [REG_AW-1:0] OFF_DIR      = 16'h0420;
  localparam logic [REG_AW-1:0] OFF_INT_CLR  = 16'h1004;
  localparam logic [REG_AW-1:0] OFF_INT_MASK = 16'h1024;
  localparam logic [REG_AW-1:0] OFF_INT_PEND = 16'h1044;
  localparam logic [REG_AW-1:0] OFF_INT_STAT = 16'h1064;

  localparam int BIT_START = 0;
  localparam int BIT_ERR   = 16;
  localparam int BIT_BUSY  = 17;
  localparam int BIT_DONE  = 18;
  localparam int IBIT_ERR  = 16;
  localparam int IBIT_DONE = 24;

  localparam logic [REG_DW-1:0] CFG_KEEP = 32'h0007_0103;

  typedef enum logic [2:0] {ST_IDLE, ST_RD0, ST_RD1, ST_WR0, ST_WR1} dmaState_t;

  typedef struct packed {
    logic load;
    logic srcAdv;
    logic dstAdv;
    logic capLo;
    logic capHi;
    logic capWord;
    logic memBeat;
    logic hiHalf;
  } pathCtl_t;
endpackage

// File: rtl/bufDmaPath.sv
module bufDmaPath import bufDmaPkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  pathCtl_t            ctl,
  input  logic                runDir,
  input  logic [ADDR_W-1:0]   srcBase,
  input  logic [ADDR_W-1:0]   dstBase,
  input  logic                srcConst,
  input  logic                dstConst,
  input  logic [2:0]          burstCode,
  input  logic                lastWord,
  input  logic [NARROW_W-1:0] bufRdData,
  input  logic [WIDE_W-1:0]   memRdData,
  output logic [ADDR_W-1:0]   bufAddr,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [NARROW_W-1:0] bufWrData,
  output logic [WIDE_W-1:0]   memWrData,
  output logic                memLast
);
  localparam logic [ADDR_W-1:0] STEP_N = ADDR_W'(NARROW_W / 8);
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(WIDE_W / 8);

  function automatic logic [BEAT_W-1:0] beatsMinusOne(input logic [2:0] code);
    case (code)
      3'd2:    return BEAT_W'(3);
      3'd3:    return BEAT_W'(7);
      3'd4:    return BEAT_W'(15);
      default: return '0;
    endcase
  endfunction

  logic [ADDR_W-1:0] srcPtr, dstPtr, srcStep, dstStep;
  logic              srcFix, dstFix;
  logic [BEAT_W-1:0] beatCnt, lenM1;
  logic [WIDE_W-1:0] word;

  assign srcStep = runDir ? STEP_W : STEP_N;
  assign dstStep = runDir ? STEP_N : STEP_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr <= '0; dstPtr <= '0; srcFix <= 1'b0; dstFix <= 1'b0;
      beatCnt <= '0; lenM1 <= '0; word <= '0;
    end else begin
      if (ctl.load) begin
        srcPtr  <= srcBase;
        dstPtr  <= dstBase;
        srcFix  <= srcConst;
        dstFix  <= dstConst;
        beatCnt <= '0;
        lenM1   <= beatsMinusOne(burstCode);
      end else begin
        if (ctl.srcAdv && !srcFix) srcPtr <= srcPtr + srcStep;
        if (ctl.dstAdv && !dstFix) dstPtr <= dstPtr + dstStep;
        if (ctl.memBeat) beatCnt <= (beatCnt == lenM1) ? '0 : beatCnt + 1'b1;
      end
      if (ctl.capLo)   word[NARROW_W-1:0]      <= bufRdData;
      if (ctl.capHi)   word[WIDE_W-1:NARROW_W] <= bufRdData;
      if (ctl.capWord) word                    <= memRdData;
    end
  end

  assign bufAddr   = runDir ? dstPtr : srcPtr;
  assign memAddr   = runDir ? srcPtr : dstPtr;
  assign bufWrData = ctl.hiHalf ? word[WIDE_W-1:NARROW_W] : word[NARROW_W-1:0];
  assign memWrData = word;
  assign memLast   = (beatCnt == lenM1) || lastWord;

  // R3: the low half captured first survives the capture of the high half
  a_r3_low_half_kept: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capHi |=> word[NARROW_W-1:0] == $past(word[NARROW_W-1:0]));
  // R5: a constant-mode source pointer never moves until the next load
  a_r5_src_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (srcFix && !ctl.load) |=> $stable(srcPtr));
  // R6: the burst beat counter wraps after its last beat
  a_r6_beat_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memBeat && !ctl.load && beatCnt == lenM1) |=> beatCnt == '0);
endmodule

// File: rtl/bufDmaCtrl.sv
module bufDmaCtrl import bufDmaPkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  output logic [REG_DW-1:0] regRdData,
  input  logic              bufAck,
  input  logic              bufErr,
  input  logic              memAck,
  input  logic              memErr,
  output logic              bufReq,
  output logic              bufWe,
  output logic              memReq,
  output logic              memWe,
  output pathCtl_t          ctl,
  output logic              runDir,
  output logic [ADDR_W-1:0] srcBase,
  output logic [ADDR_W-1:0] dstBase,
  output logic              srcConst,
  output logic              dstConst,
  output logic [2:0]        burstCode,
  output logic              lastWord,
  output logic              irq
);
  localparam int WCNT_W = ADDR_W - 2;

  logic [ADDR_W-1:0] srcAddrR, dstAddrR, sizeR;
  logic [REG_DW-1:0] srcCfgR, dstCfgR;
  logic              dirR, doneF, errF;
  logic [1:0]        intStat, intMask;   // [1] done source, [0] error source
  logic [WCNT_W-1:0] wordsLeft;
  dmaState_t         state, nextState;

  logic active, useBuf, beatAck, beatFail, wordDone, doneSet, errSet;
  logic cmdWr, cmdStart, clrDone, clrErr, intClrWr, startOk, startBad, sizeBad;

  assign cmdWr    = regWrEn && regAddr == OFF_CMD;
  assign cmdStart = cmdWr && regWrData[BIT_START];
  assign clrDone  = cmdWr && regWrData[BIT_DONE];
  assign clrErr   = cmdWr && regWrData[BIT_ERR];
  assign intClrWr = regWrEn && regAddr == OFF_INT_CLR;
  assign sizeBad  = (sizeR == '0) || (sizeR[1:0] != 2'b00);
  assign startOk  = cmdStart && state == ST_IDLE && !sizeBad;
  assign startBad = cmdStart && !startOk;

  assign active   = state != ST_IDLE;
  assign useBuf   = runDir ? (state == ST_WR0 || state == ST_WR1)
                           : (state == ST_RD0 || state == ST_RD1);
  assign beatAck  = active && (useBuf ? bufAck : memAck);
  assign beatFail = active && (useBuf ? bufErr : memErr);
  assign lastWord = wordsLeft == WCNT_W'(1);

  always_comb begin
    nextState  = state;
    ctl        = '0;
    ctl.hiHalf = state == ST_WR1;
    wordDone   = 1'b0;
    if (startOk) begin
      ctl.load  = 1'b1;
      nextState = ST_RD0;
    end else if (beatFail) begin
      nextState = ST_IDLE;
    end else if (beatAck) begin
      case (state)
        ST_RD0: begin
          ctl.srcAdv = 1'b1;
          if (runDir) begin
            ctl.capWord = 1'b1; ctl.memBeat = 1'b1; nextState = ST_WR0;
          end else begin
            ctl.capLo = 1'b1; nextState = ST_RD1;
          end
        end
        ST_RD1: begin
          ctl.srcAdv = 1'b1; ctl.capHi = 1'b1; nextState = ST_WR0;
        end
        ST_WR0: begin
          ctl.dstAdv = 1'b1;
          if (runDir) nextState = ST_WR1;
          else begin ctl.memBeat = 1'b1; wordDone = 1'b1; end
        end
        ST_WR1: begin
          ctl.dstAdv = 1'b1; wordDone = 1'b1;
        end
        default: ;
      endcase
      if (wordDone) nextState = lastWord ? ST_IDLE : ST_RD0;
    end
  end

  assign doneSet = wordDone && lastWord;
  assign errSet  = startBad || beatFail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddrR <= '0; dstAddrR <= '0; sizeR <= '0; srcCfgR <= '0; dstCfgR <= '0;
      dirR <= 1'b0; doneF <= 1'b0; errF <= 1'b0; intStat <= '0; intMask <= '0;
      wordsLeft <= '0; state <= ST_IDLE; runDir <= 1'b0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          OFF_SRC_ADDR: srcAddrR <= regWrData[ADDR_W-1:0];
          OFF_DST_ADDR: dstAddrR <= regWrData[ADDR_W-1:0];
          OFF_SRC_CFG:  srcCfgR  <= regWrData & CFG_KEEP;
          OFF_DST_CFG:  dstCfgR  <= regWrData & CFG_KEEP;
          OFF_SIZE:     sizeR    <= regWrData[ADDR_W-1:0];
          OFF_DIR:      dirR     <= regWrData[0];
          OFF_INT_MASK: intMask  <= {regWrData[IBIT_DONE], regWrData[IBIT_ERR]};
          default: ;
        endcase
      end
      state <= nextState;
      if (startOk) begin
        runDir    <= dirR;
        wordsLeft <= sizeR[ADDR_W-1:2];
      end else if (wordDone) begin
        wordsLeft <= wordsLeft - 1'b1;
      end
      doneF <= doneSet | (doneF & ~clrDone);
      errF  <= errSet  | (errF  & ~clrErr);
      intStat[1] <= doneSet | (intStat[1] & ~(intClrWr & regWrData[IBIT_DONE]));
      intStat[0] <= errSet  | (intStat[0] & ~(intClrWr & regWrData[IBIT_ERR]));
    end
  end

  assign bufReq = active && useBuf;
  assign memReq = active && !useBuf;
  assign bufWe  = runDir;
  assign memWe  = !runDir;

  assign srcBase   = srcAddrR;
  assign dstBase   = dstAddrR;
  assign srcConst  = srcCfgR[8];
  assign dstConst  = dstCfgR[8];
  assign burstCode = dirR ? srcCfgR[18:16] : dstCfgR[18:16];

  logic [1:0] intPend;
  assign intPend = intStat & ~intMask;
  assign irq     = |intPend;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFF_SRC_ADDR: regRdData = REG_DW'(srcAddrR);
      OFF_DST_ADDR: regRdData = REG_DW'(dstAddrR);
      OFF_SRC_CFG:  regRdData = srcCfgR;
      OFF_DST_CFG:  regRdData = dstCfgR;
      OFF_SIZE:     regRdData = REG_DW'(sizeR);
      OFF_DIR:      regRdData = REG_DW'(dirR);
      OFF_STAT: begin
        regRdData[BIT_DONE] = doneF;
        regRdData[BIT_BUSY] = active;
        regRdData[BIT_ERR]  = errF;
      end
      OFF_INT_MASK: begin
        regRdData[IBIT_DONE] = intMask[1]; regRdData[IBIT_ERR] = intMask[0];
      end
      OFF_INT_PEND: begin
        regRdData[IBIT_DONE] = intPend[1]; regRdData[IBIT_ERR] = intPend[0];
      end
      OFF_INT_STAT: begin
        regRdData[IBIT_DONE] = intStat[1]; regRdData[IBIT_ERR] = intStat[0];
      end
      default: ;
    endcase
  end

  // R7: done stays set unless its clear bit is written
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneF && !clrDone) |=> doneF);
  // R8: a zero-size start moves nothing and flags an error
  a_r8_zero_start: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && state == ST_IDLE && sizeR == '0) |=> (!bufReq && !memReq && errF));
  // R9: an error response ends all requests
  a_r9_err_stops: assert property (@(posedge clk) disable iff (!rstN)
    beatFail |=> (!bufReq && !memReq && errF));
  // R10: an unmasked completion raises irq
  a_r10_done_irq: assert property (@(posedge clk) disable iff (!rstN)
    (doneSet && !intMask[1] && !(regWrEn && regAddr == OFF_INT_MASK)) |=> irq);
  // R11: set beats clear in the same cycle
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (doneSet && clrDone) |=> doneF);
endmodule

// File: rtl/bufDmaEngine.sv
module bufDmaEngine import bufDmaPkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [REG_DW-1:0]   regWrData,
  output logic [REG_DW-1:0]   regRdData,
  output logic                bufReq,
  output logic                bufWe,
  output logic [ADDR_W-1:0]   bufAddr,
  output logic [NARROW_W-1:0] bufWrData,
  input  logic [NARROW_W-1:0] bufRdData,
  input  logic                bufAck,
  input  logic                bufErr,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WIDE_W-1:0]   memWrData,
  input  logic [WIDE_W-1:0]   memRdData,
  input  logic                memAck,
  input  logic                memErr,
  output logic                memLast,
  output logic                irq
);
  pathCtl_t          ctl;
  logic              runDir, srcConst, dstConst, lastWord;
  logic [ADDR_W-1:0] srcBase, dstBase;
  logic [2:0]        burstCode;

  bufDmaCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .bufAck(bufAck), .bufErr(bufErr), .memAck(memAck), .memErr(memErr),
    .bufReq(bufReq), .bufWe(bufWe), .memReq(memReq), .memWe(memWe),
    .ctl(ctl), .runDir(runDir), .srcBase(srcBase), .dstBase(dstBase),
    .srcConst(srcConst), .dstConst(dstConst), .burstCode(burstCode),
    .lastWord(lastWord), .irq(irq)
  );

  bufDmaPath #(.ADDR_W(ADDR_W)) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .runDir(runDir),
    .srcBase(srcBase), .dstBase(dstBase), .srcConst(srcConst), .dstConst(dstConst),
    .burstCode(burstCode), .lastWord(lastWord),
    .bufRdData(bufRdData), .memRdData(memRdData),
    .bufAddr(bufAddr), .memAddr(memAddr), .bufWrData(bufWrData),
    .memWrData(memWrData), .memLast(memLast)
  );
endmodule

// File: tb/bufDmaEngine_tb_top.sv
module bufDmaEngine_tb_top;
  import bufDmaPkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        regWrEn;
  logic [15:0] regAddr;
  logic [31:0] regWrData, regRdData;
  logic        bufReq, bufWe, memReq, memWe, memLast, irq;
  logic [31:0] bufAddr, memAddr, memWrData;
  logic [15:0] bufWrData;
  logic [15:0] bufRdData = '0;
  logic [31:0] memRdData = '0;
  logic bufAck = 1'b0, bufErr = 1'b0, memAck = 1'b0, memErr = 1'b0;

  logic        tWrEn = 1'b0, hWrEn = 1'b0;
  logic [15:0] tAddr = '0, hAddr = '0;
  logic [31:0] tData = '0, hData = '0;
  assign regWrEn   = tWrEn | hWrEn;
  assign regAddr   = hWrEn ? hAddr : tAddr;
  assign regWrData = hWrEn ? hData : tData;

  bufDmaEngine dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .bufReq(bufReq), .bufWe(bufWe), .bufAddr(bufAddr), .bufWrData(bufWrData),
    .bufRdData(bufRdData), .bufAck(bufAck), .bufErr(bufErr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .memAck(memAck), .memErr(memErr),
    .memLast(memLast), .irq(irq)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic        last;
  } beat_t;

  beat_t       bufQ[$];
  beat_t       memQ[$];
  logic [15:0] bufMem [256];
  logic [31:0] sysMem [256];
  int    nChk = 0, nBad = 0;
  logic  scoreOn = 1'b1, injMemErr = 1'b0;
  int    hookMode = 0;
  string curTag = "R1";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  // Monitor / responder: compares every beat against the scoreboard queues
  always @(negedge clk) begin
    hWrEn = 1'b0;
    if (bufAck || bufErr) begin
      bufAck = 1'b0; bufErr = 1'b0;
    end else if (bufReq) begin
      if (scoreOn) begin
        if (bufQ.size() == 0) check({curTag, " unexpected buffer beat"}, 32'd1, 32'd0);
        else begin
          beat_t e;
          e = bufQ.pop_front();
          check({curTag, " buffer we"}, 32'(bufWe), 32'(e.we));
          check({curTag, " buffer addr"}, bufAddr, e.addr);
          if (e.we) check({curTag, " buffer data"}, 32'(bufWrData), e.data);
        end
      end
      if (bufWe) bufMem[bufAddr[8:1]] = bufWrData;
      else bufRdData = bufMem[bufAddr[8:1]];
      bufAck = 1'b1;
    end
    if (memAck || memErr) begin
      memAck = 1'b0; memErr = 1'b0;
    end else if (memReq) begin
      if (injMemErr && memWe) begin
        memErr = 1'b1; injMemErr = 1'b0;
      end else begin
        if (scoreOn) begin
          if (memQ.size() == 0) check({curTag, " unexpected memory beat"}, 32'd1, 32'd0);
          else begin
            beat_t e;
            e = memQ.pop_front();
            check({curTag, " memory we"}, 32'(memWe), 32'(e.we));
            check({curTag, " memory addr"}, memAddr, e.addr);
            check({curTag, " R6 memLast"}, 32'(memLast), 32'(e.last));
            if (e.we) check({curTag, " memory data"}, memWrData, e.data);
            if (memWe && hookMode != 0 && memQ.size() == 0) begin
              hWrEn = 1'b1;
              hAddr = (hookMode == 1) ? OFF_CMD : OFF_INT_CLR;
              hData = (hookMode == 1) ? (32'd1 << BIT_DONE) : (32'd1 << IBIT_DONE);
              hookMode = 0;
            end
          end
        end
        if (memWe) sysMem[memAddr[9:2]] = memWrData;
        else memRdData = sysMem[memAddr[9:2]];
        memAck = 1'b1;
      end
    end
  end

  task automatic regWrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    tAddr = a; tData = d; tWrEn = 1'b1;
    @(negedge clk);
    tWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    tAddr = a;
    #1 d = regRdData;
  endtask

  task automatic expectReg(input string tag, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check(tag, v, exp);
  endtask

  function automatic int burstLen(input int code);
    case (code)
      2: return 4;
      3: return 8;
      4: return 16;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] cfgWord(input int code, input logic fix, input int width);
    return (32'(code) << 16) | (32'(fix) << 8) | 32'(width);
  endfunction

  // Driver: program registers and push the expected beats
  task automatic startCopy(input logic dir, input logic [31:0] src, input logic [31:0] dst,
                           input int srcCode, input logic srcFix, input int dstCode,
                           input logic dstFix, input int words, input logic push);
    int n;
    n = burstLen(dir ? srcCode : dstCode);
    if (push) begin
      for (int w = 0; w < words; w++) begin
        logic [31:0] sa, da, sb, db, wd;
        logic lst;
        lst = ((w % n) == n - 1) || (w == words - 1);
        if (!dir) begin
          sa = srcFix ? src : src + 32'(4*w);
          sb = srcFix ? src : sa + 32'd2;
          da = dstFix ? dst : dst + 32'(4*w);
          wd = {bufMem[sb[8:1]], bufMem[sa[8:1]]};
          bufQ.push_back('{1'b0, sa, 32'd0, 1'b0});
          bufQ.push_back('{1'b0, sb, 32'd0, 1'b0});
          memQ.push_back('{1'b1, da, wd, lst});
        end else begin
          sa = srcFix ? src : src + 32'(4*w);
          da = dstFix ? dst : dst + 32'(4*w);
          db = dstFix ? dst : da + 32'd2;
          wd = sysMem[sa[9:2]];
          memQ.push_back('{1'b0, sa, 32'd0, lst});
          bufQ.push_back('{1'b1, da, 32'(wd[15:0]), 1'b0});
          bufQ.push_back('{1'b1, db, 32'(wd[31:16]), 1'b0});
        end
      end
    end
    regWrite(OFF_SRC_ADDR, src);
    regWrite(OFF_DST_ADDR, dst);
    regWrite(OFF_SRC_CFG, cfgWord(srcCode, srcFix, dir ? 2 : 1));
    regWrite(OFF_DST_CFG, cfgWord(dstCode, dstFix, dir ? 1 : 2));
    regWrite(OFF_SIZE, 32'(4*words));
    regWrite(OFF_DIR, 32'(dir));
    regWrite(OFF_CMD, 32'd1);
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      regRead(OFF_STAT, v);
      if (!v[BIT_BUSY]) return;
    end
    check({curTag, " transfer timeout"}, 32'd1, 32'd0);
  endtask

  task automatic queuesDrained();
    check({curTag, " all expected beats seen"}, 32'(bufQ.size() + memQ.size()), 32'd0);
  endtask

  task automatic clearAll();
    regWrite(OFF_CMD, (32'd1 << BIT_DONE) | (32'd1 << BIT_ERR));
    regWrite(OFF_INT_CLR, (32'd1 << IBIT_DONE) | (32'd1 << IBIT_ERR));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  localparam logic [31:0] ST_DONE = 32'd1 << BIT_DONE;
  localparam logic [31:0] ST_ERR  = 32'd1 << BIT_ERR;
  localparam logic [31:0] I_DONE  = 32'd1 << IBIT_DONE;
  localparam logic [31:0] I_ERR   = 32'd1 << IBIT_ERR;

  initial begin
    for (int i = 0; i < 256; i++) begin
      bufMem[i] = 16'hB000 + 16'(i);
      sysMem[i] = 32'h5000_0000 + 32'(i * 3);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    curTag = "R1";
    check("R1 irq after reset", 32'(irq), 32'd0);
    check("R1 no request after reset", 32'(bufReq | memReq), 32'd0);
    begin
      logic [15:0] offs [12];
      offs = '{OFF_SRC_ADDR, OFF_SRC_CFG, OFF_DST_ADDR, OFF_DST_CFG, OFF_SIZE, OFF_CMD,
               OFF_STAT, OFF_DIR, OFF_INT_CLR, OFF_INT_MASK, OFF_INT_PEND, OFF_INT_STAT};
      for (int i = 0; i < 12; i++) expectReg("R1 register zero", offs[i], 32'd0);
    end

    // R2: register readback
    curTag = "R2";
    regWrite(OFF_SRC_ADDR, 32'h1234_5678);
    expectReg("R2 source address", OFF_SRC_ADDR, 32'h1234_5678);
    regWrite(OFF_SRC_CFG, 32'hFFFF_FFFF);
    expectReg("R2 source config fields", OFF_SRC_CFG, 32'h0007_0103);
    regWrite(OFF_DST_CFG, 32'hFFFF_FFFF);
    expectReg("R2 destination config fields", OFF_DST_CFG, 32'h0007_0103);
    regWrite(OFF_SIZE, 32'h0000_ABCD);
    expectReg("R2 size", OFF_SIZE, 32'h0000_ABCD);
    regWrite(OFF_DIR, 32'hFFFF_FFFF);
    expectReg("R2 direction", OFF_DIR, 32'd1);
    expectReg("R2 command reads zero", OFF_CMD, 32'd0);

    // R3 + R6: read direction, 4-beat bursts
    curTag = "R3";
    startCopy(1'b0, 32'h10, 32'h40, 4, 1'b0, 2, 1'b0, 8, 1'b1);
    check("R7 busy while running", 32'(bufReq | memReq), 32'd1);
    waitIdle();
    queuesDrained();
    expectReg("R7 done set", OFF_STAT, ST_DONE);
    expectReg("R7 done sticky", OFF_STAT, ST_DONE);
    expectReg("R10 status done bit", OFF_INT_STAT, I_DONE);
    expectReg("R10 pending done bit", OFF_INT_PEND, I_DONE);
    check("R10 irq on done", 32'(irq), 32'd1);
    regWrite(OFF_CMD, ST_DONE);
    expectReg("R7 done cleared by command", OFF_STAT, 32'd0);
    regWrite(OFF_INT_CLR, I_DONE);
    expectReg("R10 status cleared", OFF_INT_STAT, 32'd0);
    check("R10 irq cleared", 32'(irq), 32'd0);

    // R4 + R6: write direction, 8-beat bursts on memory side
    curTag = "R4";
    startCopy(1'b1, 32'h40, 32'h100, 3, 1'b0, 4, 1'b0, 10, 1'b1);
    waitIdle();
    queuesDrained();
    expectReg("R4 done", OFF_STAT, ST_DONE);
    clearAll();

    // R5: constant destination, then constant source with single beats
    curTag = "R5";
    startCopy(1'b0, 32'h20, 32'h80, 4, 1'b0, 4, 1'b1, 2, 1'b1);
    waitIdle();
    queuesDrained();
    startCopy(1'b0, 32'h30, 32'hC0, 0, 1'b1, 0, 1'b0, 3, 1'b1);
    waitIdle();
    queuesDrained();
    clearAll();

    // R8: zero and misaligned sizes
    curTag = "R8";
    regWrite(OFF_SIZE, 32'd0);
    regWrite(OFF_CMD, 32'd1);
    repeat (4) @(negedge clk);
    expectReg("R8 zero size flags error", OFF_STAT, ST_ERR);
    expectReg("R10 error interrupt status", OFF_INT_STAT, I_ERR);
    check("R10 irq on error", 32'(irq), 32'd1);
    clearAll();
    expectReg("R7 error cleared by command", OFF_STAT, 32'd0);
    regWrite(OFF_SIZE, 32'd6);
    regWrite(OFF_CMD, 32'd1);
    repeat (4) @(negedge clk);
    expectReg("R8 misaligned size flags error", OFF_STAT, ST_ERR);
    queuesDrained();
    clearAll();

    // R8: start while busy
    startCopy(1'b0, 32'h0, 32'h200, 4, 1'b0, 4, 1'b0, 16, 1'b1);
    regWrite(OFF_CMD, 32'd1);
    waitIdle();
    queuesDrained();
    expectReg("R8 busy start errors, transfer completes", OFF_STAT, ST_DONE | ST_ERR);
    clearAll();

    // R9: memory error response ends the transfer
    curTag = "R9";
    scoreOn = 1'b0;
    injMemErr = 1'b1;
    startCopy(1'b0, 32'h0, 32'h300, 4, 1'b0, 4, 1'b0, 4, 1'b0);
    waitIdle();
    expectReg("R9 error without done", OFF_STAT, ST_ERR);
    begin
      int reqSeen;
      reqSeen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (bufReq || memReq) reqSeen++;
      end
      check("R9 no requests after error", 32'(reqSeen), 32'd0);
    end
    scoreOn = 1'b1;
    clearAll();

    // R10: masking
    curTag = "R10";
    regWrite(OFF_INT_MASK, I_DONE);
    expectReg("R10 mask readback", OFF_INT_MASK, I_DONE);
    startCopy(1'b0, 32'h50, 32'h340, 4, 1'b0, 4, 1'b0, 1, 1'b1);
    waitIdle();
    queuesDrained();
    check("R10 masked irq low", 32'(irq), 32'd0);
    expectReg("R10 masked pending zero", OFF_INT_PEND, 32'd0);
    expectReg("R10 masked status still latched", OFF_INT_STAT, I_DONE);
    regWrite(OFF_INT_MASK, 32'd0);
    check("R10 unmask raises irq", 32'(irq), 32'd1);
    expectReg("R10 unmasked pending", OFF_INT_PEND, I_DONE);
    clearAll();

    // R11: completion coincides with a clear
    curTag = "R11";
    hookMode = 1;
    startCopy(1'b0, 32'h60, 32'h380, 4, 1'b0, 4, 1'b0, 2, 1'b1);
    waitIdle();
    queuesDrained();
    expectReg("R11 done survives same-cycle clear", OFF_STAT, ST_DONE);
    regWrite(OFF_CMD, ST_DONE);
    expectReg("R11 lone clear drops done", OFF_STAT, 32'd0);
    hookMode = 2;
    startCopy(1'b0, 32'h70, 32'h3C0, 4, 1'b0, 4, 1'b0, 2, 1'b1);
    waitIdle();
    queuesDrained();
    expectReg("R11 interrupt status survives same-cycle clear", OFF_INT_STAT, I_DONE);
    regWrite(OFF_INT_CLR, I_DONE);
    expectReg("R11 lone interrupt clear", OFF_INT_STAT, 32'd0);

    report();
    $finish;
  end
endmodule